// File: doc/BRIEF.md
# Device Register Front-End with Loopback Test Registers

This block answers host register accesses to an 8 KiB device window. It decodes each request into a region and performs the access. The regions are a guard area that always returns a marker pattern, and 32-bit and 64-bit loopback test registers that return double the stored value. A test-interrupt trigger sends one vector out on an interrupt-request port. A write-only control word turns bit 0 into a one-cycle reset request. The remaining regions are a port-enable bitmap, a read-only link-status bitmap, a physical port count and a fixed 64-bit device identifier. Every other offset in the window is a reserved hole.

The host bus carries a byte address, 64-bit write data and eight byte strobes. Address bits [12:3] select an 8-byte slot. Strobe bits [3:0] cover the low 32-bit half and strobe bits [7:4] cover the high half, lane-aligned. The block is always ready. A read returns the whole 8-byte slot one cycle after acceptance, with `rsp_valid` high for that cycle. A write takes effect at the accepting clock edge. A 64-bit register can be written in one access, or in two 32-bit accesses with the lower half first. The lower half waits in a staging register until the upper half arrives.

Top module: `devreg_frontend`

## Requirements
- R1: Slots 0x000 and 0x008 form a guard area. Writes there change nothing, and a read returns 0xDEADBABE_DEADBABE.
- R2: Any access to an offset outside the mapped slots, or with a nonzero address[2:0], is reserved. It reads 0 and its writes change no state.
- R3: The 32-bit test word (slot 0x010, low half) reads back as twice the last value written, modulo 2^32. The high half of that slot reads 0.
- R4: The 64-bit test word (slot 0x018) reads back as twice its value, modulo 2^64. Strobe 0xFF writes all 64 bits. Strobe 0x0F only stages the low half and leaves the readable value unchanged. A following strobe 0xF0 write loads {high data, staged low}.
- R5: A write with strobe[3:0]=0xF to slot 0x020 gives `irq_valid` high for exactly the next cycle, with `irq_vector` = wdata[7:0]. A read of that slot returns the last vector in bits [7:0].
- R6: The port-enable bitmap (slot 0x318) resets to 0 and follows the same full/staged write rules as R4. Bits 0 and 63 always read 0.
- R7: A read of slot 0x310 returns link_up[i] in bit i+1 for each port i. Bits 0 and 63 read 0, and writes there change nothing.
- R8: A read of slot 0x300 returns the port count NPORTS in bits [63:32] and 0 in bits [31:0]. A read of slot 0x320 returns DEV_ID.
- R9: A write to slot 0x300 with strobe[3:0]=0xF and wdata[0]=1 raises `reset_req` for exactly the next cycle. A write with wdata[0]=0 raises nothing.
- R10: A read gives `rsp_valid` high for exactly the cycle after acceptance. A write gives no `rsp_valid`. After reset all stored registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (13) | Byte address in the window |
| req_wdata | input | 64 | Lane-aligned write data |
| req_wstrb | input | 8 | Byte strobes; [3:0] low half, [7:4] high half |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data of the addressed slot |
| link_up | input | NPORTS (62) | Link state of ports 1..NPORTS |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | VEC_W (8) | Vector of the request |
| reset_req | output | 1 | One-cycle device reset request |

## Verification
The assertions assume that `req_valid` is low while reset is held, so every `$past` term in the first cycle after reset sees an idle bus. They also assume that the strobe halves are all-ones or all-zeros, because partial halves are simply ignored. The bench drives requests on the falling edge, one per cycle, with only whole-half strobe patterns, and keeps the bus idle during reset. It holds `link_up` steady around each status read, so the returned bitmap is determined by the value applied.

// File: rtl/devreg_pkg.sv
package devreg_pkg;

  localparam int unsigned SLOT_W = 10;

  localparam logic [SLOT_W-1:0] SL_GUARD0 = 10'h000;
  localparam logic [SLOT_W-1:0] SL_GUARD1 = 10'h001;
  localparam logic [SLOT_W-1:0] SL_T32    = 10'h002;
  localparam logic [SLOT_W-1:0] SL_T64    = 10'h003;
  localparam logic [SLOT_W-1:0] SL_IRQ    = 10'h004;
  localparam logic [SLOT_W-1:0] SL_CTLCNT = 10'h060;
  localparam logic [SLOT_W-1:0] SL_LINK   = 10'h062;
  localparam logic [SLOT_W-1:0] SL_PEN    = 10'h063;
  localparam logic [SLOT_W-1:0] SL_ID     = 10'h064;

  localparam logic [31:0] GUARD_WORD = 32'hDEADBABE;

  typedef enum logic [3:0] {
    RG_RESV,
    RG_GUARD,
    RG_T32,
    RG_T64,
    RG_IRQ,
    RG_CTLCNT,
    RG_LINK,
    RG_PEN,
    RG_ID
  } region_e;

  function automatic logic [31:0] twice32(input logic [31:0] v);
    return {v[30:0], 1'b0};
  endfunction

  function automatic logic [63:0] twice64(input logic [63:0] v);
    return {v[62:0], 1'b0};
  endfunction

endpackage

// File: rtl/devreg_decode.sv
module devreg_decode
  import devreg_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);
  localparam int unsigned SW = ADDR_W - 3;

  logic [SW-1:0] slot;
  assign slot = addr[ADDR_W-1:3];

  always_comb begin
    region = RG_RESV;
    if (addr[2:0] == 3'b000) begin
      if (SW'(SL_GUARD0) == slot || SW'(SL_GUARD1) == slot) region = RG_GUARD;
      else if (SW'(SL_T32)    == slot) region = RG_T32;
      else if (SW'(SL_T64)    == slot) region = RG_T64;
      else if (SW'(SL_IRQ)    == slot) region = RG_IRQ;
      else if (SW'(SL_CTLCNT) == slot) region = RG_CTLCNT;
      else if (SW'(SL_LINK)   == slot) region = RG_LINK;
      else if (SW'(SL_PEN)    == slot) region = RG_PEN;
      else if (SW'(SL_ID)     == slot) region = RG_ID;
    end
  end
endmodule

// File: rtl/devreg_split64.sv
module devreg_split64 #(
  parameter logic [63:0] KEEP_MASK = 64'hFFFF_FFFF_FFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [63:0] wdata,
  output logic [63:0] value
);
  logic [31:0] stage_q;
  logic [63:0] value_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      value_q <= '0;
    end else if (wr_lo && wr_hi) begin
      value_q <= wdata & KEEP_MASK;
    end else if (wr_lo) begin
      stage_q <= wdata[31:0];
    end else if (wr_hi) begin
      value_q <= {wdata[63:32], stage_q} & KEEP_MASK;
    end
  end

  assign value = value_q;

  // R4 / R6: a lone low-half write only stages
  p_stage_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi) |=> $stable(value));

  // R6: masked bit positions never become set
  p_masked_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (value & ~KEEP_MASK) == 64'h0);

  // R4: an upper-half write merges the staged low half
  p_merge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo) |=> value[31:0] == ($past(stage_q) & KEEP_MASK[31:0]));
endmodule

// File: rtl/devreg_frontend.sv
module devreg_frontend
  import devreg_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned NPORTS = 62,
  parameter int unsigned VEC_W  = 8,
  parameter logic [63:0] DEV_ID = 64'h5A17_0C00_0000_0042
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  input  logic [7:0]        req_wstrb,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata,
  input  logic [NPORTS-1:0] link_up,
  output logic              irq_valid,
  output logic [VEC_W-1:0]  irq_vector,
  output logic              reset_req
);
  localparam int unsigned PAD_W = 64 - NPORTS - 1;
  localparam logic [63:0] PEN_MASK = {PAD_W'(0), {NPORTS{1'b1}}, 1'b0};

  region_e region;
  logic    acc, wr_acc, rd_acc, lo_full, hi_full;
  logic    wr_lo_t64, wr_hi_t64, wr_lo_pen, wr_hi_pen;
  logic    irq_fire, rst_fire, resv_write;

  logic [31:0]      t32_q;
  logic [VEC_W-1:0] vec_q;
  logic [63:0]      t64_val, pen_val, rd_mux, rdata_q;
  logic             rvalid_q, irq_q, rstreq_q;

  devreg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (req_addr),
    .region (region)
  );

  assign req_ready  = 1'b1;
  assign acc        = req_valid && req_ready;
  assign wr_acc     = acc && req_write;
  assign rd_acc     = acc && !req_write;
  assign lo_full    = (req_wstrb[3:0] == 4'hF);
  assign hi_full    = (req_wstrb[7:4] == 4'hF);

  assign wr_lo_t64  = wr_acc && region == RG_T64 && lo_full;
  assign wr_hi_t64  = wr_acc && region == RG_T64 && hi_full;
  assign wr_lo_pen  = wr_acc && region == RG_PEN && lo_full;
  assign wr_hi_pen  = wr_acc && region == RG_PEN && hi_full;
  assign irq_fire   = wr_acc && region == RG_IRQ && lo_full;
  assign rst_fire   = wr_acc && region == RG_CTLCNT && lo_full && req_wdata[0];
  assign resv_write = wr_acc && (region == RG_RESV || region == RG_GUARD
                                 || region == RG_LINK || region == RG_ID);

  devreg_split64 #(.KEEP_MASK(64'hFFFF_FFFF_FFFF_FFFF)) u_t64 (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_lo (wr_lo_t64),
    .wr_hi (wr_hi_t64),
    .wdata (req_wdata),
    .value (t64_val)
  );

  devreg_split64 #(.KEEP_MASK(PEN_MASK)) u_pen (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_lo (wr_lo_pen),
    .wr_hi (wr_hi_pen),
    .wdata (req_wdata),
    .value (pen_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t32_q <= '0;
      vec_q <= '0;
    end else begin
      if (wr_acc && region == RG_T32 && lo_full) t32_q <= req_wdata[31:0];
      if (irq_fire) vec_q <= req_wdata[VEC_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (region)
      RG_GUARD:  rd_mux = {GUARD_WORD, GUARD_WORD};
      RG_T32:    rd_mux = {32'h0, twice32(t32_q)};
      RG_T64:    rd_mux = twice64(t64_val);
      RG_IRQ:    rd_mux = 64'(vec_q);
      RG_CTLCNT: rd_mux = {32'(NPORTS), 32'h0};
      RG_LINK:   rd_mux = {PAD_W'(0), link_up, 1'b0};
      RG_PEN:    rd_mux = pen_val;
      RG_ID:     rd_mux = DEV_ID;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
      irq_q    <= 1'b0;
      rstreq_q <= 1'b0;
    end else begin
      rvalid_q <= rd_acc;
      if (rd_acc) rdata_q <= rd_mux;
      irq_q    <= irq_fire;
      rstreq_q <= rst_fire;
    end
  end

  assign rsp_valid  = rvalid_q;
  assign rsp_rdata  = rdata_q;
  assign irq_valid  = irq_q;
  assign irq_vector = vec_q;
  assign reset_req  = rstreq_q;

  // R1: guard reads return the marker pattern
  p_guard_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && region == RG_GUARD) |=> rsp_rdata == {GUARD_WORD, GUARD_WORD});

  // R2: reserved and read-only writes leave all stored state untouched
  p_resv_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    resv_write |=> ($stable(t32_q) && $stable(t64_val) && $stable(pen_val) && $stable(vec_q)));

  // R3: test word readback is the doubled stored value
  p_t32_double_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && region == RG_T32) |=> rsp_rdata[31:0] == {$past(t32_q[30:0]), 1'b0});

  // R5: an interrupt request only follows a trigger write
  p_irq_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> $past(wr_acc && region == RG_IRQ && lo_full));

  // R9: reset request only follows a control write with bit 0 set
  p_rst_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(wr_acc && region == RG_CTLCNT && req_wdata[0]));

  // R10: read data valid exactly one cycle after a read
  p_rsp_timing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd_acc));

  p_rsp_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rsp_valid);
endmodule

// File: tb/tb_devreg_frontend.sv
module tb_devreg_frontend;
  localparam int unsigned NPORTS = 62;
  localparam logic [63:0] DEV_ID = 64'h5A17_0C00_0000_0042;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [12:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [7:0]  req_wstrb = '0;
  logic        rsp_valid, irq_valid, reset_req;
  logic [63:0] rsp_rdata;
  logic [7:0]  irq_vector;
  logic [NPORTS-1:0] link_up = '0;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  devreg_frontend #(.NPORTS(NPORTS), .DEV_ID(DEV_ID)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_wstrb(req_wstrb), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .link_up(link_up), .irq_valid(irq_valid), .irq_vector(irq_vector),
    .reset_req(reset_req)
  );

  typedef struct packed {
    logic        wr;
    logic [12:0] addr;
    logic [7:0]  strb;
    logic [63:0] data;
    logic [63:0] exp;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 13'h010, 8'h0F, 64'h0000_0000_8000_0003, 64'h0, 8'd3},                  // R3
    '{1'b0, 13'h010, 8'h00, 64'h0, 64'h0000_0000_0000_0006, 8'd3},                  // R3 wrap
    '{1'b1, 13'h018, 8'hFF, 64'h1234_5678_9ABC_DEF0, 64'h0, 8'd4},                  // R4
    '{1'b0, 13'h018, 8'h00, 64'h0, 64'h2468_ACF1_3579_BDE0, 8'd4},                  // R4
    '{1'b1, 13'h018, 8'h0F, 64'h0000_0000_0000_0001, 64'h0, 8'd4},                  // R4 stage
    '{1'b0, 13'h018, 8'h00, 64'h0, 64'h2468_ACF1_3579_BDE0, 8'd4},                  // R4 unchanged
    '{1'b1, 13'h018, 8'hF0, 64'h8000_0000_0000_0000, 64'h0, 8'd4},                  // R4 merge
    '{1'b0, 13'h018, 8'h00, 64'h0, 64'h0000_0000_0000_0002, 8'd4},                  // R4 wrap
    '{1'b1, 13'h000, 8'hFF, 64'h1111_2222_3333_4444, 64'h0, 8'd1},                  // R1
    '{1'b0, 13'h000, 8'h00, 64'h0, 64'hDEAD_BABE_DEAD_BABE, 8'd1},                  // R1
    '{1'b0, 13'h008, 8'h00, 64'h0, 64'hDEAD_BABE_DEAD_BABE, 8'd1},                  // R1
    '{1'b1, 13'h100, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 8'd2},                  // R2
    '{1'b0, 13'h100, 8'h00, 64'h0, 64'h0, 8'd2},                                    // R2
    '{1'b1, 13'h014, 8'hFF, 64'h7777_7777_7777_7777, 64'h0, 8'd2},                  // R2 misaligned
    '{1'b0, 13'h010, 8'h00, 64'h0, 64'h0000_0000_0000_0006, 8'd2},                  // R2 no effect
    '{1'b1, 13'h318, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 8'd6},                  // R6
    '{1'b0, 13'h318, 8'h00, 64'h0, 64'h7FFF_FFFF_FFFF_FFFE, 8'd6},                  // R6 edges
    '{1'b1, 13'h318, 8'h0F, 64'h0, 64'h0, 8'd6},                                    // R6 stage
    '{1'b1, 13'h318, 8'hF0, 64'h0000_0001_0000_0000, 64'h0, 8'd6},                  // R6 merge
    '{1'b0, 13'h318, 8'h00, 64'h0, 64'h0000_0001_0000_0000, 8'd6}                   // R6
  };

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic op(input logic wr, input logic [12:0] a, input logic [7:0] s,
                    input logic [63:0] d);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wstrb = s; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_wstrb = '0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    check("R10 reset outputs", {61'h0, rsp_valid, irq_valid, reset_req}, 64'h0);
    op(1'b0, 13'h318, 8'h00, 64'h0);
    check("R10 pen reset", rsp_rdata, 64'h0);
    check("R10 rsp_valid read", {63'h0, rsp_valid}, 64'h1);
    op(1'b0, 13'h018, 8'h00, 64'h0);
    check("R10 t64 reset", rsp_rdata, 64'h0);

    for (int i = 0; i < NV; i++) begin
      op(TBL[i].wr, TBL[i].addr, TBL[i].strb, TBL[i].data);
      if (!TBL[i].wr)
        check($sformatf("R%0d vec%0d", TBL[i].rq, i), rsp_rdata, TBL[i].exp);
      else
        check($sformatf("R10 no rsp on write vec%0d", i), {63'h0, rsp_valid}, 64'h0);
    end

    // R7: link status bitmap
    link_up = '0;
    link_up[0] = 1'b1; link_up[NPORTS-1] = 1'b1; link_up[9] = 1'b1;
    op(1'b0, 13'h310, 8'h00, 64'h0);
    check("R7 link map", rsp_rdata, 64'h4000_0000_0000_0402);
    link_up = '1;
    op(1'b1, 13'h310, 8'hFF, 64'h0);
    op(1'b0, 13'h310, 8'h00, 64'h0);
    check("R7 link all up", rsp_rdata, 64'h7FFF_FFFF_FFFF_FFFE);

    // R8: count and identifier
    op(1'b0, 13'h300, 8'h00, 64'h0);
    check("R8 count slot", rsp_rdata, {32'd62, 32'h0});
    op(1'b1, 13'h320, 8'hFF, 64'h0);
    op(1'b0, 13'h320, 8'h00, 64'h0);
    check("R8 device id", rsp_rdata, DEV_ID);

    // R5: interrupt trigger
    op(1'b1, 13'h020, 8'h0F, 64'h0000_0000_0000_002A);
    check("R5 irq pulse", {55'h0, irq_valid, irq_vector}, {55'h0, 1'b1, 8'h2A});
    @(negedge clk);
    check("R5 irq single", {63'h0, irq_valid}, 64'h0);
    op(1'b0, 13'h020, 8'h00, 64'h0);
    check("R5 vector readback", rsp_rdata, 64'h2A);
    op(1'b1, 13'h020, 8'hF0, 64'hFFFF_FFFF_0000_0011);
    check("R5 no irq on high half", {63'h0, irq_valid}, 64'h0);

    // R9: reset request
    op(1'b1, 13'h300, 8'h0F, 64'h1);
    check("R9 reset pulse", {63'h0, reset_req}, 64'h1);
    @(negedge clk);
    check("R9 reset single", {63'h0, reset_req}, 64'h0);
    op(1'b1, 13'h300, 8'h0F, 64'h0);
    check("R9 no pulse on zero", {63'h0, reset_req}, 64'h0);
    op(1'b0, 13'h300, 8'h00, 64'h0);
    check("R9 control reads zero", {32'h0, rsp_rdata[31:0]}, 64'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule